// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small accumulator-based controller. Each operation takes the accumulator value, a second operand, the current status byte and a 3-bit operation code. One clock edge after `issue_i` it presents the new accumulator byte, the byte bound for the dedicated B register, and an updated status byte. Operations that do not change a flag copy it from the incoming status byte.

Add, add-with-carry and subtract-with-borrow set the carry, half-carry and signed-overflow flags. AND, OR and XOR leave those three flags as they were. Unsigned multiply returns a 16-bit product split across the two result bytes. Unsigned divide returns the quotient and the remainder. The parity bit always follows the registered accumulator. The bank-select bits, the user flags and the spare bit pass through without change. Instruction decode, register file access and decimal adjust belong to the surrounding controller.

Top module: `acc_alu`

## Requirements
- R1: After reset, `acc_o`, `breg_o` and `psw_o` are all zero and `done_o` is low.
- R2: A result appears on the outputs at the first rising edge after `issue_i` is sampled high, and `done_o` is high in that cycle only. While `issue_i` is low, `acc_o`, `breg_o` and `psw_o` keep their values.
- R3: The operation codes are: 0 add, 1 add with carry, 2 subtract with borrow, 3 AND, 4 OR, 5 XOR, 6 multiply, 7 divide. The status byte layout is: bit 7 carry (CY), bit 6 half-carry (AC), bit 2 overflow (OV), bit 0 parity (P). For codes 0 to 2, `acc_o` is the low byte of A+B, A+B+CY or A−B−CY, where CY is taken from `psw_i`. CY out is set on a carry out of bit 7 for an add, or on a borrow into bit 7 for a subtract.
- R4: For codes 0 to 2, AC is set when the low nibble carries into bit 4 for an add, or borrows from bit 4 for a subtract. It is cleared otherwise.
- R5: For codes 0 to 2, OV is set exactly when the result, read as a signed byte, lies outside −128..127.
- R6: Codes 3 to 5 give the bitwise AND, OR and XOR of A and B. CY, AC and OV are copied from `psw_i`.
- R7: Multiply (code 6) puts the low product byte in `acc_o` and the high byte in `breg_o`. It clears CY, sets OV when the product exceeds 255, and copies AC from `psw_i`.
- R8: Divide (code 7) with a nonzero divisor puts the quotient in `acc_o` and the remainder in `breg_o`, and clears CY and OV. With a zero divisor it sets OV, clears CY, and the two result bytes carry no defined value.
- R9: `psw_o` bit 0 always equals the XOR of all bits of `acc_o`.
- R10: Status bits 5, 4, 3 and 1 are copied from `psw_i` for every operation.
- R11: Codes 0 to 5 leave `breg_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Start an operation this cycle |
| op_i | input | 3 | Operation code |
| acc_i | input | 8 | Accumulator operand A |
| opnd_i | input | 8 | Second operand B |
| psw_i | input | 8 | Incoming status byte |
| acc_o | output | 8 | New accumulator value |
| breg_o | output | 8 | Byte for the B register |
| psw_o | output | 8 | Updated status byte |
| done_o | output | 1 | Result valid this cycle |

## Verification
The bench aims at the flag boundaries. It uses 0x7F+1 and 0x80−1 to hit signed overflow, 0xFF+1 to hit a carry with a zero result, and a low-nibble borrow where the high nibbles are equal. A design that takes overflow from the carry out alone, or that reverses the sense of the half-carry on subtract, fails these cases. The bench also tests a multiply product of exactly 255 against 256, a divide by zero, and a logic operation applied with all three arithmetic flags set. A design that clears flags on logic operations, or that forgets the high product byte, shows up there. Stretches with no issue and random inputs confirm that the outputs hold. A design that updates B on add, or parity from the operand, fails those checks.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADDC = 3'd1,
        OP_SUBB = 3'd2,
        OP_AND  = 3'd3,
        OP_OR   = 3'd4,
        OP_XOR  = 3'd5,
        OP_MUL  = 3'd6,
        OP_DIV  = 3'd7
    } alu_op_e;

    // status byte bit positions
    localparam int PSW_CY = 7;
    localparam int PSW_AC = 6;
    localparam int PSW_OV = 2;
    localparam int PSW_P  = 0;

endpackage

// File: rtl/acc_addsub.sv
`timescale 1ns/1ps
module acc_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o,
    output logic         cy_o,
    output logic         ac_o,
    output logic         ov_o
);
    localparam int H = W / 2;

    logic [W:0]   full;
    logic [H:0]   low;
    logic [W-1:0] mid;

    always_comb begin
        if (sub_i) begin
            full = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
            low  = {1'b0, a_i[H-1:0]} - {1'b0, b_i[H-1:0]} - {{H{1'b0}}, cin_i};
            mid  = {1'b0, a_i[W-2:0]} - {1'b0, b_i[W-2:0]} - {{(W-1){1'b0}}, cin_i};
        end else begin
            full = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
            low  = {1'b0, a_i[H-1:0]} + {1'b0, b_i[H-1:0]} + {{H{1'b0}}, cin_i};
            mid  = {1'b0, a_i[W-2:0]} + {1'b0, b_i[W-2:0]} + {{(W-1){1'b0}}, cin_i};
        end
        res_o = full[W-1:0];
        cy_o  = full[W];
        ac_o  = low[H];
        ov_o  = mid[W-1] ^ full[W];
    end
endmodule

// File: rtl/acc_mul.sv
`timescale 1ns/1ps
module acc_mul #(
    parameter int W = 8
) (
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [2*W-1:0] prod_o
);
    localparam int PW = 2 * W;

    logic [PW-1:0] part_s [0:W];

    assign part_s[0] = '0;

    for (genvar i = 0; i < W; i++) begin : g_row
        assign part_s[i+1] = part_s[i] + (b_i[i] ? ({{W{1'b0}}, a_i} << i) : '0);
    end

    assign prod_o = part_s[W];
endmodule

// File: rtl/acc_div.sv
`timescale 1ns/1ps
module acc_div #(
    parameter int W = 8
) (
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);
    logic [W-1:0] rem_s [0:W];

    assign rem_s[0] = '0;

    for (genvar s = 0; s < W; s++) begin : g_step
        localparam int BI = W - 1 - s;
        logic [W:0] shl;
        logic [W:0] trial;
        assign shl          = {rem_s[s], num_i[BI]};
        assign trial        = shl - {1'b0, den_i};
        assign quo_o[BI]    = ~trial[W];
        assign rem_s[s+1]   = trial[W] ? shl[W-1:0] : trial[W-1:0];
    end

    assign rem_o = rem_s[W];
endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         issue_i,
    input  logic [2:0]   op_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] opnd_i,
    input  logic [7:0]   psw_i,
    output logic [W-1:0] acc_o,
    output logic [W-1:0] breg_o,
    output logic [7:0]   psw_o,
    output logic         done_o
);
    typedef struct packed {
        logic [W-1:0] acc;
        logic [W-1:0] breg;
        logic [7:0]   psw;
        logic         done;
    } state_t;

    state_t st_d, st_q;

    logic         as_sub_d, as_cin_d;
    logic [W-1:0] as_res_d;
    logic         as_cy_d, as_ac_d, as_ov_d;
    logic [2*W-1:0] prod_d;
    logic [W-1:0] quo_d, rem_d;

    always_comb begin
        as_sub_d = (alu_op_e'(op_i) == OP_SUBB);
        as_cin_d = (alu_op_e'(op_i) == OP_ADD) ? 1'b0 : psw_i[PSW_CY];
    end

    acc_addsub #(.W(W)) addsub_i (
        .a_i   (acc_i),
        .b_i   (opnd_i),
        .cin_i (as_cin_d),
        .sub_i (as_sub_d),
        .res_o (as_res_d),
        .cy_o  (as_cy_d),
        .ac_o  (as_ac_d),
        .ov_o  (as_ov_d)
    );

    acc_mul #(.W(W)) mul_i (
        .a_i    (acc_i),
        .b_i    (opnd_i),
        .prod_o (prod_d)
    );

    acc_div #(.W(W)) div_i (
        .num_i (acc_i),
        .den_i (opnd_i),
        .quo_o (quo_d),
        .rem_o (rem_d)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = issue_i;
        if (issue_i) begin
            st_d.psw = psw_i;
            unique case (alu_op_e'(op_i))
                OP_ADD, OP_ADDC, OP_SUBB: begin
                    st_d.acc         = as_res_d;
                    st_d.psw[PSW_CY] = as_cy_d;
                    st_d.psw[PSW_AC] = as_ac_d;
                    st_d.psw[PSW_OV] = as_ov_d;
                end
                OP_AND: st_d.acc = acc_i & opnd_i;
                OP_OR:  st_d.acc = acc_i | opnd_i;
                OP_XOR: st_d.acc = acc_i ^ opnd_i;
                OP_MUL: begin
                    st_d.acc         = prod_d[W-1:0];
                    st_d.breg        = prod_d[2*W-1:W];
                    st_d.psw[PSW_CY] = 1'b0;
                    st_d.psw[PSW_OV] = |prod_d[2*W-1:W];
                end
                OP_DIV: begin
                    st_d.acc         = quo_d;
                    st_d.breg        = rem_d;
                    st_d.psw[PSW_CY] = 1'b0;
                    st_d.psw[PSW_OV] = ~|opnd_i;
                end
                default: st_d.acc = st_q.acc;
            endcase
            st_d.psw[PSW_P] = ^st_d.acc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o  = st_q.acc;
    assign breg_o = st_q.breg;
    assign psw_o  = st_q.psw;
    assign done_o = st_q.done;
endmodule

// File: rtl/acc_alu_chk.sv
`timescale 1ns/1ps
module acc_alu_chk
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         issue_i,
    input logic [2:0]   op_i,
    input logic [W-1:0] acc_i,
    input logic [W-1:0] opnd_i,
    input logic [7:0]   psw_i,
    input logic [W-1:0] acc_o,
    input logic [W-1:0] breg_o,
    input logic [7:0]   psw_o,
    input logic         done_o
);
    localparam int DW2 = 2 * W;

    a_r2_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |=> done_o);

    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> (!done_o && $stable(acc_o) && $stable(breg_o) && $stable(psw_o)));

    a_r6_logic_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR)) |=>
        (psw_o[PSW_CY] == $past(psw_i[PSW_CY]) && psw_o[PSW_AC] == $past(psw_i[PSW_AC])
         && psw_o[PSW_OV] == $past(psw_i[PSW_OV])));

    a_r7_mul_product: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && op_i == OP_MUL) |=>
        ({breg_o, acc_o} == DW2'($past(acc_i)) * DW2'($past(opnd_i)) && !psw_o[PSW_CY]));

    a_r8_div_result: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && op_i == OP_DIV && opnd_i != '0) |=>
        ((DW2'(acc_o) * DW2'($past(opnd_i)) + DW2'(breg_o) == DW2'($past(acc_i)))
         && (breg_o < $past(opnd_i)) && !psw_o[PSW_OV] && !psw_o[PSW_CY]));

    a_r8_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && op_i == OP_DIV && opnd_i == '0) |=> (psw_o[PSW_OV] && !psw_o[PSW_CY]));

    a_r9_parity: assert property (@(posedge clk) disable iff (!rst_n)
        psw_o[PSW_P] == ^acc_o);

    a_r10_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |=> (psw_o[5:3] == $past(psw_i[5:3]) && psw_o[1] == $past(psw_i[1])));

    a_r11_b_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && op_i != OP_MUL && op_i != OP_DIV) |=> $stable(breg_o));
endmodule

bind acc_alu acc_alu_chk #(.W(W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue_i (issue_i),
    .op_i    (op_i),
    .acc_i   (acc_i),
    .opnd_i  (opnd_i),
    .psw_i   (psw_i),
    .acc_o   (acc_o),
    .breg_o  (breg_o),
    .psw_o   (psw_o),
    .done_o  (done_o)
);

// File: tb/acc_alu_tb_top.sv
`timescale 1ns/1ps
module acc_alu_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       issue_i = 1'b0;
    logic [2:0] op_i = '0;
    logic [7:0] acc_i = '0, opnd_i = '0, psw_i = '0;
    logic [7:0] acc_o, breg_o, psw_o;
    logic       done_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [7:0] exp_b = '0;

    always #4 clk = ~clk;

    acc_alu dut_i (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i),
        .acc_i(acc_i), .opnd_i(opnd_i), .psw_i(psw_i),
        .acc_o(acc_o), .breg_o(breg_o), .psw_o(psw_o), .done_o(done_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic issue_op(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
                            input logic [7:0] psw);
        @(negedge clk);
        op_i = op; acc_i = a; opnd_i = b; psw_i = psw; issue_i = 1'b1;
        @(negedge clk);
        issue_i = 1'b0;
    endtask

    // reference model written from the requirements, integer arithmetic
    task automatic run_op(input string req, input logic [2:0] op, input logic [7:0] a,
                          input logic [7:0] b, input logic [7:0] psw);
        int c, s, sa, sb, ss, lo;
        logic [7:0] ea, eb;
        logic cy, ac, ov;
        bit acc_known;
        acc_known = 1'b1;
        eb = exp_b;
        cy = psw[7]; ac = psw[6]; ov = psw[2];
        ea = '0;
        c  = (op == 3'd0) ? 0 : int'(psw[7]);
        sa = int'($signed(a)); sb = int'($signed(b));
        case (op)
            3'd0, 3'd1: begin
                s = int'(a) + int'(b) + c; ea = s[7:0]; cy = (s > 255);
                lo = int'(a[3:0]) + int'(b[3:0]) + c; ac = (lo > 15);
                ss = sa + sb + c; ov = (ss > 127) || (ss < -128);
            end
            3'd2: begin
                s = int'(a) - int'(b) - c; ea = s[7:0]; cy = (s < 0);
                lo = int'(a[3:0]) - int'(b[3:0]) - c; ac = (lo < 0);
                ss = sa - sb - c; ov = (ss > 127) || (ss < -128);
            end
            3'd3: ea = a & b;
            3'd4: ea = a | b;
            3'd5: ea = a ^ b;
            3'd6: begin
                s = int'(a) * int'(b); ea = s[7:0]; eb = s[15:8];
                cy = 1'b0; ov = (s > 255);
            end
            default: begin
                cy = 1'b0;
                if (b == 0) begin
                    ov = 1'b1; acc_known = 1'b0;
                end else begin
                    ea = 8'(int'(a) / int'(b)); eb = 8'(int'(a) % int'(b)); ov = 1'b0;
                end
            end
        endcase
        issue_op(op, a, b, psw);
        check(req, "done", int'(done_o), 1);
        if (acc_known) begin
            check(req, "acc", int'(acc_o), int'(ea));
            check(req, "breg", int'(breg_o), int'(eb));
            exp_b = eb;
        end else begin
            exp_b = breg_o;
        end
        check(req, "cy", int'(psw_o[7]), int'(cy));
        check(req, "ac", int'(psw_o[6]), int'(ac));
        check(req, "ov", int'(psw_o[2]), int'(ov));
        check("R10", "passthru", int'({psw_o[5:3], psw_o[1]}), int'({psw[5:3], psw[1]}));
        check("R9", "parity", int'(psw_o[0]), int'(^acc_o));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "acc", int'(acc_o), 0);
        check("R1", "breg", int'(breg_o), 0);
        check("R1", "psw", int'(psw_o), 0);
        check("R1", "done", int'(done_o), 0);
    endtask

    task automatic t_add_sub();
        run_op("R5", 3'd0, 8'h7F, 8'h01, 8'h00);   // signed overflow, half carry
        check("R5", "ov set", int'(psw_o[2]), 1);
        run_op("R3", 3'd0, 8'hFF, 8'h01, 8'h80);   // ADD ignores incoming carry
        check("R3", "zero with carry", int'({psw_o[7], acc_o}), 9'h100);
        run_op("R4", 3'd1, 8'h0F, 8'h00, 8'h80);   // carry in ripples into bit 4
        check("R4", "ac from cin", int'(psw_o[6]), 1);
        run_op("R3", 3'd2, 8'h00, 8'h01, 8'h00);   // borrow
        run_op("R5", 3'd2, 8'h80, 8'h01, 8'h00);   // signed underflow
        run_op("R4", 3'd2, 8'h10, 8'h0F, 8'h80);   // nibble borrow, result zero
        run_op("R4", 3'd2, 8'h35, 8'h12, 8'hC4);   // no borrow anywhere
    endtask

    task automatic t_logic();
        run_op("R6", 3'd3, 8'hF0, 8'h3C, 8'hC4);
        run_op("R6", 3'd4, 8'h0F, 8'h30, 8'h3A);
        run_op("R6", 3'd5, 8'hAA, 8'hFF, 8'hFE);
    endtask

    task automatic t_mul();
        run_op("R7", 3'd6, 8'h10, 8'h10, 8'hC0);   // product 256
        run_op("R7", 3'd6, 8'h0F, 8'h11, 8'h80);   // product 255
        run_op("R7", 3'd6, 8'hFF, 8'hFF, 8'h00);
        run_op("R11", 3'd0, 8'h01, 8'h02, 8'h00);  // B untouched by add
    endtask

    task automatic t_div();
        run_op("R8", 3'd7, 8'd200, 8'd7, 8'h84);
        run_op("R8", 3'd7, 8'd5, 8'd9, 8'h00);
        run_op("R8", 3'd7, 8'hFF, 8'h01, 8'h00);
        run_op("R8", 3'd7, 8'h42, 8'h00, 8'h80);   // divisor zero
    endtask

    task automatic t_hold();
        logic [7:0] a0, b0, p0;
        a0 = acc_o; b0 = breg_o; p0 = psw_o;
        @(negedge clk);
        op_i = 3'd6; acc_i = 8'h55; opnd_i = 8'h77; psw_i = 8'hFF;
        repeat (3) @(negedge clk);
        check("R2", "acc held", int'(acc_o), int'(a0));
        check("R2", "breg held", int'(breg_o), int'(b0));
        check("R2", "psw held", int'(psw_o), int'(p0));
        check("R2", "done low", int'(done_o), 0);
    endtask

    task automatic t_sweep();
        logic [31:0] lcg = 32'h1234_5678;
        for (int i = 0; i < 200; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            run_op("R3", lcg[26:24], lcg[7:0], lcg[15:8], lcg[23:16]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_add_sub();
        t_logic();
        t_hold();
        t_mul();
        t_div();
        t_hold();
        t_sweep();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule